// File: doc/BRIEF.md
# Nibble-Wide Call/Return Stack Sequencer

This block keeps the return stack of a 4-bit processor in the upper 64 nibbles of its data RAM, at addresses 0x3C0 to 0x3FF. When the core calls a subroutine or enters an interrupt, it raises a push request. The block then saves a 16-bit frame into four consecutive nibbles, one write per clock. The frame holds the 14-bit program counter, the status bit and the carry bit. A return request reads the frame back, one nibble per clock. A plain return gives back only the program counter. A return-from-interrupt also gives back status and carry.

The stack holds up to 16 levels. Level 1 sits at the four highest addresses, and each deeper level sits four addresses lower. The block counts active levels in a depth register. It reports completion with a one-cycle done pulse and sets sticky error flags when a push finds the stack full or a return finds it empty. Stack nibbles that hold no active level are never touched, so the core can use them as ordinary data. A strobe resets the depth to zero.

Top module: `nib_stack`

## Requirements
- R1: After reset, depth_o is 0, done_o, busy_o, ovf_o and unf_o are 0, and neither RAM strobe is asserted.
- R2: A push at depth d writes four nibbles on four consecutive cycles, to addresses 0x3FC-4d, +1, +2 and +3 in ascending order. The first nibble is {status, carry, pc[13:12]} with status in bit 3. The next three are pc[11:8], pc[7:4] and pc[3:0].
- R3: Each completed operation gives exactly one done_o pulse, one cycle wide, after its last RAM access. Depth changes only in that cycle, by +1 for a push and by -1 for a return, or through the reset-stack strobe.
- R4: A plain return (ret_i) reads the top frame and drives it onto pc_o. It loads st_o and ca_o from the core's current st_i and ca_i, not from the stack.
- R5: A return-from-interrupt (reti_i) drives pc_o, st_o and ca_o from the popped frame.
- R6: Frames come back in last-in-first-out order across all 16 levels.
- R7: A push at depth 16 writes nothing, keeps the depth at 16, sets ovf_o and still gives a done pulse.
- R8: A return at depth 0 reads nothing, keeps the depth at 0, sets unf_o and still gives a done pulse.
- R9: A one-cycle rst_sp_i strobe sets depth_o to 0 and clears ovf_o and unf_o on the next cycle.
- R10: Requests raised while busy_o is high are ignored. If push_i and a return request are raised together, the push wins.
- R11: The block writes no address outside the frame being pushed. Any stack nibble outside an active level keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Start a push (call or interrupt entry) |
| ret_i | input | 1 | Start a plain return |
| reti_i | input | 1 | Start a return-from-interrupt |
| rst_sp_i | input | 1 | Force the depth to zero and clear the error flags |
| pc_i | input | 14 | Program counter to save |
| st_i | input | 1 | Current status bit |
| ca_i | input | 1 | Current carry bit |
| pc_o | output | 14 | Restored program counter |
| st_o | output | 1 | Status after the last return |
| ca_o | output | 1 | Carry after the last return |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |
| depth_o | output | 5 | Active stack levels (0 to 16) |
| ovf_o | output | 1 | Sticky flag: a push found the stack full |
| unf_o | output | 1 | Sticky flag: a return found the stack empty |
| mem_we_o | output | 1 | RAM write strobe |
| mem_re_o | output | 1 | RAM read strobe |
| mem_addr_o | output | 10 | RAM nibble address |
| mem_wdata_o | output | 4 | RAM write data |
| mem_rdata_i | input | 4 | RAM read data, valid the cycle after mem_re_o |

## Verification
The assertions assume that rst_sp_i arrives only while the block is idle. They also assume the RAM returns read data exactly one cycle after the read strobe. The bench raises a request for a single cycle, and only while the block is idle, apart from the deliberate busy-collision scenario. It pulses rst_sp_i only after done_o has been seen. Its RAM model is a synchronous nibble memory with one cycle of read latency.

// File: rtl/nst_pkg.sv
package nst_pkg;
  localparam int NIB_W      = 4;
  localparam int FRAME_NIBS = 4;
  localparam int FRAME_W    = NIB_W * FRAME_NIBS;
  localparam int PC_W       = 14;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_FIN} nst_state_e;
  typedef enum logic [1:0] {OP_PUSH, OP_RET, OP_RETI} nst_op_e;

  // frame = {status, carry, pc}; nibble 0 is the most significant
  function automatic logic [NIB_W-1:0] frame_nib(logic [FRAME_W-1:0] f, int idx);
    logic [FRAME_W-1:0] s;
    s = f >> (NIB_W * (FRAME_NIBS - 1 - idx));
    return s[NIB_W-1:0];
  endfunction
endpackage

// File: rtl/nst_addr.sv
module nst_addr #(
  parameter int ADDR_W  = 10,
  parameter int BASE    = 'h3C0,
  parameter int LEVELS  = 16,
  parameter int DEPTH_W = 5,
  parameter int CNT_W   = 2
) (
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               is_pop_i,
  input  logic [CNT_W-1:0]   idx_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int FN = nst_pkg::FRAME_NIBS;

  logic [DEPTH_W-1:0] lvl;
  int unsigned        off;

  always_comb begin
    // level 1 at the top of the region; push targets depth+1, pop targets depth
    lvl    = is_pop_i ? depth_i : depth_i + 1'b1;
    off    = FN * (LEVELS - int'(lvl)) + int'(idx_i);
    addr_o = ADDR_W'(BASE + off);
  end
endmodule

// File: rtl/nst_frame.sv
module nst_frame #(
  parameter int CNT_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cap_i,
  input  logic [CNT_W-1:0]              cap_idx_i,
  input  logic [nst_pkg::NIB_W-1:0]     rdata_i,
  output logic [nst_pkg::FRAME_W-1:0]   frame_nx_o
);
  import nst_pkg::*;

  logic [NIB_W-1:0] nib_q  [FRAME_NIBS];
  logic [NIB_W-1:0] nib_nx [FRAME_NIBS];

  for (genvar g = 0; g < FRAME_NIBS; g++) begin : g_nib
    always_comb
      nib_nx[g] = (cap_i && int'(cap_idx_i) == g) ? rdata_i : nib_q[g];

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) nib_q[g] <= '0;
      else         nib_q[g] <= nib_nx[g];

    assign frame_nx_o[FRAME_W-1-g*NIB_W -: NIB_W] = nib_nx[g];
  end
endmodule

// File: rtl/nst_ctrl.sv
module nst_ctrl #(
  parameter int LEVELS  = 16,
  parameter int DEPTH_W = 5,
  parameter int CNT_W   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic                ret_i,
  input  logic                reti_i,
  input  logic                rst_sp_i,
  output nst_pkg::nst_state_e state_o,
  output nst_pkg::nst_op_e    op_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                err_o,
  output logic [DEPTH_W-1:0]  depth_o,
  output logic                ovf_o,
  output logic                unf_o,
  output logic                done_o
);
  import nst_pkg::*;

  localparam logic [CNT_W-1:0]   CNT_LAST = CNT_W'(FRAME_NIBS - 1);
  localparam logic [DEPTH_W-1:0] FULL     = DEPTH_W'(LEVELS);

  nst_state_e        state_q;
  nst_op_e           op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PUSH;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      depth_o <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (push_i) begin
            op_q    <= OP_PUSH;
            err_q   <= (depth_o == FULL);
            state_q <= (depth_o == FULL) ? ST_FIN : ST_ACC;
          end else if (ret_i || reti_i) begin
            op_q    <= reti_i ? OP_RETI : OP_RET;
            err_q   <= (depth_o == '0);
            state_q <= (depth_o == '0) ? ST_FIN : ST_ACC;
          end
        end
        ST_ACC: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) state_q <= ST_FIN;
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          if (err_q) begin
            if (op_q == OP_PUSH) ovf_o <= 1'b1;
            else                 unf_o <= 1'b1;
          end else if (op_q == OP_PUSH) begin
            depth_o <= depth_o + 1'b1;
          end else begin
            depth_o <= depth_o - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (rst_sp_i) begin
        depth_o <= '0;
        ovf_o   <= 1'b0;
        unf_o   <= 1'b0;
      end
    end
  end

  assign state_o = state_q;
  assign op_o    = op_q;
  assign cnt_o   = cnt_q;
  assign err_o   = err_q;
endmodule

// File: rtl/nib_stack.sv
module nib_stack #(
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h3C0,
  parameter int LEVELS = 16,
  localparam int DEPTH_W = $clog2(LEVELS + 1),
  localparam int CNT_W   = $clog2(nst_pkg::FRAME_NIBS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_i,
  input  logic                      ret_i,
  input  logic                      reti_i,
  input  logic                      rst_sp_i,
  input  logic [nst_pkg::PC_W-1:0]  pc_i,
  input  logic                      st_i,
  input  logic                      ca_i,
  output logic [nst_pkg::PC_W-1:0]  pc_o,
  output logic                      st_o,
  output logic                      ca_o,
  output logic                      done_o,
  output logic                      busy_o,
  output logic [DEPTH_W-1:0]        depth_o,
  output logic                      ovf_o,
  output logic                      unf_o,
  output logic                      mem_we_o,
  output logic                      mem_re_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [nst_pkg::NIB_W-1:0] mem_wdata_o,
  input  logic [nst_pkg::NIB_W-1:0] mem_rdata_i
);
  import nst_pkg::*;

  nst_state_e         state;
  nst_op_e            op;
  logic [CNT_W-1:0]   cnt;
  logic               err;
  logic [FRAME_W-1:0] tx_q;
  logic [FRAME_W-1:0] rx_nx;
  logic               rd_pend_q;
  logic [CNT_W-1:0]   rd_idx_q;

  nst_ctrl #(.LEVELS(LEVELS), .DEPTH_W(DEPTH_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .push_i, .ret_i, .reti_i, .rst_sp_i,
    .state_o(state), .op_o(op), .cnt_o(cnt), .err_o(err),
    .depth_o, .ovf_o, .unf_o, .done_o
  );

  nst_addr #(.ADDR_W(ADDR_W), .BASE(BASE), .LEVELS(LEVELS),
             .DEPTH_W(DEPTH_W), .CNT_W(CNT_W)) u_addr (
    .depth_i(depth_o), .is_pop_i(op != OP_PUSH), .idx_i(cnt), .addr_o(mem_addr_o)
  );

  nst_frame #(.CNT_W(CNT_W)) u_frame (
    .clk_i, .rst_ni, .cap_i(rd_pend_q), .cap_idx_i(rd_idx_q),
    .rdata_i(mem_rdata_i), .frame_nx_o(rx_nx)
  );

  assign busy_o      = (state != ST_IDLE);
  assign mem_we_o    = (state == ST_ACC) && (op == OP_PUSH);
  assign mem_re_o    = (state == ST_ACC) && (op != OP_PUSH);
  assign mem_wdata_o = frame_nib(tx_q, int'(cnt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q      <= '0;
      rd_pend_q <= 1'b0;
      rd_idx_q  <= '0;
      pc_o      <= '0;
      st_o      <= 1'b0;
      ca_o      <= 1'b0;
    end else begin
      rd_pend_q <= mem_re_o;
      rd_idx_q  <= cnt;
      if (state == ST_IDLE && push_i) tx_q <= {st_i, ca_i, pc_i};
      // last nibble lands during FIN; rx_nx already merges it
      if (state == ST_FIN && !err && op != OP_PUSH) begin
        pc_o <= rx_nx[PC_W-1:0];
        if (op == OP_RETI) begin
          st_o <= rx_nx[FRAME_W-1];
          ca_o <= rx_nx[FRAME_W-2];
        end else begin
          st_o <= st_i;
          ca_o <= ca_i;
        end
      end
    end
  end
endmodule

// File: rtl/nib_stack_chk.sv
module nib_stack_chk #(
  parameter int ADDR_W  = 10,
  parameter int BASE    = 'h3C0,
  parameter int LEVELS  = 16,
  parameter int DEPTH_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rst_sp_i,
  input logic               done_o,
  input logic               busy_o,
  input logic [DEPTH_W-1:0] depth_o,
  input logic               ovf_o,
  input logic               unf_o,
  input logic               mem_we_o,
  input logic               mem_re_o,
  input logic [ADDR_W-1:0]  mem_addr_o
);
  localparam int TOP = BASE + LEVELS * nst_pkg::FRAME_NIBS - 1;

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_depth_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(depth_o) |-> (done_o || $past(rst_sp_i)));

  assert_wr_ascend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) + 1'b1);

  assert_no_rw_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  assert_depth_max_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(depth_o) <= LEVELS);

  assert_ovf_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> int'(depth_o) == LEVELS);

  assert_unf_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unf_o) |-> depth_o == '0);

  assert_sp_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_sp_i |=> (depth_o == '0 && !ovf_o && !unf_o));

  assert_idle_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_addr_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> (int'(mem_addr_o) >= BASE && int'(mem_addr_o) <= TOP
                                && busy_o));
endmodule

bind nib_stack nib_stack_chk #(
  .ADDR_W(ADDR_W), .BASE(BASE), .LEVELS(LEVELS), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk_i, .rst_ni, .rst_sp_i, .done_o, .busy_o, .depth_o, .ovf_o, .unf_o,
  .mem_we_o, .mem_re_o, .mem_addr_o
);

// File: tb/sim_nib_stack.sv
`timescale 1ns/1ps
module sim_nib_stack;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push = 0, ret = 0, reti = 0, rst_sp = 0, st = 0, ca = 0;
  logic [13:0] pc = '0;
  logic [13:0] pc_o;
  logic st_o, ca_o, done, busy, ovf, unf, we, re;
  logic [4:0] depth;
  logic [9:0] addr;
  logic [3:0] wdata, rdata;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  logic [3:0] ram [0:1023];
  int wr_n = 0, rd_n = 0;
  logic [9:0] wr_a [4];
  logic [3:0] wr_d [4];
  int wr_t [4];
  logic [15:0] shadow [17];

  always #2.5 clk = ~clk;

  nib_stack u0 (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .ret_i(ret), .reti_i(reti),
    .rst_sp_i(rst_sp), .pc_i(pc), .st_i(st), .ca_i(ca), .pc_o(pc_o), .st_o(st_o),
    .ca_o(ca_o), .done_o(done), .busy_o(busy), .depth_o(depth), .ovf_o(ovf),
    .unf_o(unf), .mem_we_o(we), .mem_re_o(re), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (we) begin
      ram[addr] <= wdata;
      if (wr_n < 4) begin wr_a[wr_n] <= addr; wr_d[wr_n] <= wdata; wr_t[wr_n] <= cyc; end
      wr_n <= wr_n + 1;
    end
    if (re) begin rdata <= ram[addr]; rd_n <= rd_n + 1; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    wr_n = 0; rd_n = 0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    chk(seen, req, "done pulse seen", int'(seen), 1);
    @(negedge clk);
    chk(!done, "R3", "done one cycle wide", int'(done), 0);
  endtask

  task automatic do_push(input logic [13:0] p, input logic s, input logic c);
    int d = int'(depth);
    int base = 'h3FC - 4 * d;
    logic [15:0] f = {s, c, p};
    clear_log();
    pc = p; st = s; ca = c; push = 1;
    @(negedge clk); push = 0;
    wait_done("R2");
    chk(wr_n == 4, "R2", "write count", wr_n, 4);
    for (int k = 0; k < 4; k++) begin
      chk(int'(wr_a[k]) == base + k, "R2", "write addr", int'(wr_a[k]), base + k);
      chk(wr_d[k] == f[15-4*k -: 4], "R2", "write nibble", int'(wr_d[k]), int'(f[15-4*k -: 4]));
      chk(wr_t[k] == wr_t[0] + k, "R2", "consecutive cycles", wr_t[k] - wr_t[0], k);
    end
    chk(int'(depth) == d + 1, "R3", "depth after push", int'(depth), d + 1);
    shadow[d + 1] = f;
  endtask

  task automatic do_pop(input bit intr, input logic cur_st, input logic cur_ca, input string req);
    int d = int'(depth);
    logic [15:0] f = shadow[d];
    clear_log();
    st = cur_st; ca = cur_ca;
    if (intr) reti = 1; else ret = 1;
    @(negedge clk); reti = 0; ret = 0;
    wait_done(req);
    chk(rd_n == 4, req, "read count", rd_n, 4);
    chk(pc_o == f[13:0], req, "pc restored", int'(pc_o), int'(f[13:0]));
    chk(st_o == (intr ? f[15] : cur_st), req, "status", int'(st_o), int'(intr ? f[15] : cur_st));
    chk(ca_o == (intr ? f[14] : cur_ca), req, "carry", int'(ca_o), int'(intr ? f[14] : cur_ca));
    chk(int'(depth) == d - 1, "R3", "depth after pop", int'(depth), d - 1);
  endtask

  task automatic t_reset();
    chk(depth == 0 && !done && !busy, "R1", "depth/done/busy", int'({depth, done, busy}), 0);
    chk(!ovf && !unf && !we && !re, "R1", "flags/strobes", int'({ovf, unf, we, re}), 0);
  endtask

  task automatic t_plain_ret();
    do_push(14'h2A5C, 1'b1, 1'b1);
    chk(ram['h3F8] == 4'h5 && ram['h3FB] == 4'h5, "R11", "neighbour level untouched",
        int'(ram['h3F8]), 5);
    do_pop(1'b0, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_reti();
    do_push(14'h1F03, 1'b1, 1'b0);
    do_pop(1'b1, 1'b0, 1'b1, "R5");
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++)
      do_push(14'((i * 14'h0357) ^ 14'h2C41), 1'(i[0]), 1'(i[1]));
    clear_log();
    push = 1; @(negedge clk); push = 0;
    wait_done("R7");
    chk(wr_n == 0, "R7", "no write when full", wr_n, 0);
    chk(ovf && depth == 16, "R7", "ovf set, depth kept", int'({ovf, depth}), 'h30);
    for (int i = 0; i < 16; i++) do_pop(1'b1, 1'b0, 1'b0, "R6");
    clear_log();
    ret = 1; @(negedge clk); ret = 0;
    wait_done("R8");
    chk(rd_n == 0, "R8", "no read when empty", rd_n, 0);
    chk(unf && depth == 0, "R8", "unf set, depth kept", int'({unf, depth}), 'h20);
  endtask

  task automatic t_rst_sp();
    do_push(14'h0011, 1'b0, 1'b1);
    do_push(14'h0022, 1'b1, 1'b0);
    rst_sp = 1; @(negedge clk); rst_sp = 0;
    chk(depth == 0 && !ovf && !unf, "R9", "depth and flags cleared", int'({ovf, unf, depth}), 0);
  endtask

  task automatic t_busy();
    clear_log();
    pc = 14'h3333; st = 0; ca = 0; push = 1; ret = 1;
    @(negedge clk); push = 0; ret = 0;
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
    wait_done("R10");
    chk(depth == 1 && wr_n == 4 && rd_n == 0, "R10", "push won, busy request ignored",
        int'(depth), 1);
    repeat (8) @(negedge clk);
    chk(!done && depth == 1 && rd_n == 0, "R10", "no late operation", int'(rd_n), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ram[i] = 4'h5;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain_ret();
    t_reti();
    t_fill();
    t_rst_sp();
    t_busy();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule